// File: doc/BRIEF.md
# Decode-Stage Branch Resolver with Fetch Squash

This block owns the fetch program counter and the fetch-to-decode pipeline register of a five-stage in-order pipeline, and settles conditional branches while they sit in the decode stage. Each branch tests one source register for zero or non-zero. Its target is the address after the branch plus a word-scaled, sign-extended offset. Because the zero test and the target adder sit in decode, a taken branch costs at most one cycle. A branch that is not taken costs nothing.

Fetch always continues down the sequential path. When a branch in decode resolves taken, fetch restarts at the target on the next edge. The word fetched in the same cycle is either replaced by a no-op bubble, or, with the delay-slot mode selected, kept as a slot that always executes. The instruction memory and the register file sit outside the block. The block presents the fetch address and the source register index. It receives the fetched word, the register value and a flag that says whether that value is current yet.

Top module: `brx_branch_unit`

## Requirements
- R1: Only a valid decode word whose bits [31:26] equal 6'b000100 (branch if zero) or 6'b000101 (branch if non-zero) can redirect fetch. Any other opcode never asserts `br_taken`. Bits [25:21] of the decode word appear on `rs_idx`.
- R2: A branch-if-zero is taken when all bits of `rs_value` are zero, and a branch-if-non-zero is taken when any bit is set. `br_taken` is combinational in the decode cycle.
- R3: `br_target` equals `id_pc4` plus the sign-extension of bits [15:0] of the decode word, shifted left by 2, with the sum wrapping at the address width.
- R4: When no branch is taken and nothing is held, `imem_addr` advances by 4 on each edge. The fetched word enters the decode register with `id_valid` = 1 and `id_pc4` = its address + 4, so a not-taken branch loses no cycle.
- R5: With `delay_mode` = 0, a taken branch loads `br_target` into `imem_addr` on the next edge. The decode register becomes the all-zero no-op with `id_valid` = 0, which gives exactly one bubble.
- R6: With `delay_mode` = 1, a taken branch also loads `br_target`, but the word fetched alongside the branch enters decode with `id_valid` = 1, and nothing is squashed.
- R7: While a branch is in decode and `rs_ready` = 0, `id_hold` is 1, `br_taken` is 0, and the fetch address and the decode register keep their values.
- R8: A synchronous reset sets `imem_addr` to RESET_PC and the decode register to the all-zero no-op with `id_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| delay_mode | input | 1 | 1: the word after a branch is a delay slot that always executes |
| imem_addr | output | PC_W | Fetch address (current PC) |
| imem_rdata | input | 32 | Word fetched from `imem_addr` |
| rs_idx | output | 5 | Source register index of the decode word |
| rs_value | input | DATA_W | Value of register `rs_idx` |
| rs_ready | input | 1 | 1 when `rs_value` is current (no pending producer) |
| id_instr | output | 32 | Decode-stage instruction word |
| id_pc4 | output | PC_W | Address following the decode-stage instruction |
| id_valid | output | 1 | Write enable of the decode-stage instruction (0 for a bubble) |
| id_hold | output | 1 | Branch in decode waiting for its operand |
| br_taken | output | 1 | Branch in decode resolves taken this cycle |
| br_target | output | PC_W | Branch target address computed in decode |

## Verification
A table of branch cases pairs both opcodes with zero, non-zero and sign-bit-only register values. The register values separate a full-width zero test from a partial one. The offsets include positive, minus one and the most negative value, which expose missing sign extension, a missing shift or a wrong base address. Each case runs with and without the delay-slot mode, which tells a squash apart from a kept slot, and a non-branch opcode with a zero register shows that decode alone gates the redirect. Directed runs then hold a branch on a late operand and release it, let straight-line code flow for several cycles, and check the reset state before every case.

// File: rtl/brx_pkg.sv
package brx_pkg;

    localparam int INSTR_W  = 32;
    localparam int OPC_W    = 6;
    localparam int REG_IDX_W = 5;
    localparam int OFS_W    = 16;

    localparam int OPC_MSB  = 31;
    localparam int OPC_LSB  = 26;
    localparam int SRC_MSB  = 25;
    localparam int SRC_LSB  = 21;
    localparam int OFS_MSB  = 15;

    localparam logic [OPC_W-1:0] OPC_BR_ZERO    = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BR_NONZERO = 6'b000101;

    localparam logic [INSTR_W-1:0] BUBBLE_WORD = '0;

    typedef enum logic [1:0] {
        BK_NONE    = 2'd0,
        BK_ZERO    = 2'd1,
        BK_NONZERO = 2'd2
    } br_kind_e;

    typedef struct packed {
        logic is_branch;
        logic cond_met;
        logic taken;
        logic hold;
    } br_dec_t;

    function automatic br_kind_e classify(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_BR_ZERO:    return BK_ZERO;
            OPC_BR_NONZERO: return BK_NONZERO;
            default:        return BK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/brx_cond_eval.sv
module brx_cond_eval
    import brx_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int DATA_W = 32
) (
    input  logic                 valid,
    input  logic [OPC_W-1:0]     opc,
    input  logic [OFS_W-1:0]     ofs,
    input  logic [PC_W-1:0]      pc4,
    input  logic [DATA_W-1:0]    rs_value,
    input  logic                 rs_ready,
    output br_dec_t              dec,
    output logic [PC_W-1:0]      target
);
    localparam int SCALED_W = OFS_W + 2;

    br_kind_e         kind;
    logic             is_zero;
    logic [PC_W-1:0]  ofs_scaled;

    assign kind    = valid ? classify(opc) : BK_NONE;
    assign is_zero = (rs_value == '0);

    generate
        if (PC_W > SCALED_W) begin : g_wide
            assign ofs_scaled = {{(PC_W-SCALED_W){ofs[OFS_W-1]}}, ofs, 2'b00};
        end else begin : g_narrow
            logic [SCALED_W-1:0] full;
            assign full       = {ofs, 2'b00};
            assign ofs_scaled = full[PC_W-1:0];
        end
    endgenerate

    assign target = pc4 + ofs_scaled;

    always_comb begin
        dec.is_branch = (kind != BK_NONE);
        unique case (kind)
            BK_ZERO:    dec.cond_met = is_zero;
            BK_NONZERO: dec.cond_met = !is_zero;
            default:    dec.cond_met = 1'b0;
        endcase
        dec.hold  = dec.is_branch && !rs_ready;
        dec.taken = dec.is_branch && rs_ready && dec.cond_met;
    end

endmodule

// File: rtl/brx_pc_reg.sv
module brx_pc_reg #(
    parameter int               PC_W     = 32,
    parameter logic [PC_W-1:0]  RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            redirect,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] pc_seq
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic [PC_W-1:0] pc_nxt;

    assign pc_seq = pc + STEP;

    always_comb begin
        if (hold)          pc_nxt = pc;
        else if (redirect) pc_nxt = target;
        else               pc_nxt = pc_seq;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= RESET_PC;
        else     pc <= pc_nxt;
    end

    AST_PC_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        hold |=> pc == $past(pc)); // R7
    AST_PC_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!hold && !redirect) |=> pc == $past(pc) + STEP); // R4
    AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (!hold && redirect) |=> pc == $past(target)); // R5

endmodule

// File: rtl/brx_ifid_reg.sv
module brx_ifid_reg
    import brx_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               squash,
    input  logic [INSTR_W-1:0] fetch_word,
    input  logic [PC_W-1:0]    fetch_pc4,
    output logic [INSTR_W-1:0] instr,
    output logic [PC_W-1:0]    pc4,
    output logic               valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            instr <= BUBBLE_WORD;
            pc4   <= '0;
            valid <= 1'b0;
        end else if (hold) begin
            instr <= instr;
            pc4   <= pc4;
            valid <= valid;
        end else if (squash) begin
            instr <= BUBBLE_WORD;
            pc4   <= fetch_pc4;
            valid <= 1'b0;
        end else begin
            instr <= fetch_word;
            pc4   <= fetch_pc4;
            valid <= 1'b1;
        end
    end

    AST_SQUASH_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        (squash && !hold) |=> (!valid && instr == BUBBLE_WORD)); // R5
    AST_HOLD_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(instr) && $stable(valid)); // R7
    AST_FLOW_VALID: assert property (@(posedge clk) disable iff (rst)
        (!hold && !squash) |=> valid); // R4

endmodule

// File: rtl/brx_branch_unit.sv
module brx_branch_unit
    import brx_pkg::*;
#(
    parameter int               PC_W     = 32,
    parameter int               DATA_W   = 32,
    parameter logic [PC_W-1:0]  RESET_PC = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  delay_mode,
    output logic [PC_W-1:0]       imem_addr,
    input  logic [INSTR_W-1:0]    imem_rdata,
    output logic [REG_IDX_W-1:0]  rs_idx,
    input  logic [DATA_W-1:0]     rs_value,
    input  logic                  rs_ready,
    output logic [INSTR_W-1:0]    id_instr,
    output logic [PC_W-1:0]       id_pc4,
    output logic                  id_valid,
    output logic                  id_hold,
    output logic                  br_taken,
    output logic [PC_W-1:0]       br_target
);
    br_dec_t          dec;
    logic [PC_W-1:0]  pc_seq;
    logic             squash;

    assign squash = dec.taken && !delay_mode;
    assign rs_idx = id_instr[SRC_MSB:SRC_LSB];

    brx_cond_eval #(
        .PC_W   (PC_W),
        .DATA_W (DATA_W)
    ) u_cond (
        .valid    (id_valid),
        .opc      (id_instr[OPC_MSB:OPC_LSB]),
        .ofs      (id_instr[OFS_MSB:0]),
        .pc4      (id_pc4),
        .rs_value (rs_value),
        .rs_ready (rs_ready),
        .dec      (dec),
        .target   (br_target)
    );

    brx_pc_reg #(
        .PC_W     (PC_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk      (clk),
        .rst      (rst),
        .hold     (dec.hold),
        .redirect (dec.taken),
        .target   (br_target),
        .pc       (imem_addr),
        .pc_seq   (pc_seq)
    );

    brx_ifid_reg #(
        .PC_W (PC_W)
    ) u_ifid (
        .clk        (clk),
        .rst        (rst),
        .hold       (dec.hold),
        .squash     (squash),
        .fetch_word (imem_rdata),
        .fetch_pc4  (pc_seq),
        .instr      (id_instr),
        .pc4        (id_pc4),
        .valid      (id_valid)
    );

    assign id_hold  = dec.hold;
    assign br_taken = dec.taken;

    AST_REDIRECT_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (id_valid && (id_instr[OPC_MSB:OPC_LSB] == OPC_BR_ZERO
                                || id_instr[OPC_MSB:OPC_LSB] == OPC_BR_NONZERO))); // R1
    AST_ZERO_TEST: assert property (@(posedge clk) disable iff (rst)
        (br_taken && id_instr[OPC_MSB:OPC_LSB] == OPC_BR_ZERO) |-> rs_value == '0); // R2
    AST_DELAY_SLOT_KEPT: assert property (@(posedge clk) disable iff (rst)
        (br_taken && delay_mode) |=> (id_valid && id_instr == $past(imem_rdata))); // R6
    AST_HOLD_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (id_hold |-> !br_taken) and (id_hold |=> imem_addr == $past(imem_addr))); // R7
    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (imem_addr == RESET_PC && !id_valid)); // R8

endmodule

// File: tb/test_brx_branch_unit.sv
module test_brx_branch_unit;
    localparam int PC_W = 32;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              delay_mode = 1'b0;
    logic [PC_W-1:0]   imem_addr;
    logic [31:0]       imem_rdata;
    logic [4:0]        rs_idx;
    logic [DATA_W-1:0] rs_value = '0;
    logic              rs_ready = 1'b1;
    logic [31:0]       id_instr;
    logic [PC_W-1:0]   id_pc4;
    logic              id_valid, id_hold, br_taken;
    logic [PC_W-1:0]   br_target;

    logic [31:0] mem [16];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign imem_rdata = mem[imem_addr[5:2]];

    brx_branch_unit #(.PC_W(PC_W), .DATA_W(DATA_W), .RESET_PC('0)) i_brx_branch_unit (
        .clk(clk), .rst(rst), .delay_mode(delay_mode),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .rs_idx(rs_idx), .rs_value(rs_value), .rs_ready(rs_ready),
        .id_instr(id_instr), .id_pc4(id_pc4), .id_valid(id_valid),
        .id_hold(id_hold), .br_taken(br_taken), .br_target(br_target)
    );

    // {opcode[55:50], offset[49:34], reg value[33:2], delay_mode[1], expect taken[0]}
    localparam logic [55:0] VECS [8] = '{
        {6'h04, 16'h0003, 32'h0000_0000, 1'b0, 1'b1},
        {6'h04, 16'h0003, 32'h0000_0005, 1'b0, 1'b0},
        {6'h05, 16'hFFFF, 32'h0000_0005, 1'b0, 1'b1},
        {6'h05, 16'h0007, 32'h0000_0000, 1'b0, 1'b0},
        {6'h04, 16'h8000, 32'h0000_0000, 1'b1, 1'b1},
        {6'h05, 16'h0002, 32'h8000_0000, 1'b1, 1'b1},
        {6'h28, 16'h0004, 32'h0000_0000, 1'b0, 1'b0},
        {6'h04, 16'h0006, 32'h0000_0001, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic fill_straight();
        for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        chk("R8", "reset pc", imem_addr, 32'h0);
        chk("R8", "reset valid", {31'b0, id_valid}, 32'h0);
        chk("R8", "reset word", id_instr, 32'h0);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] tgt(input logic [15:0] ofs);
        return 32'd4 + {{14{ofs[15]}}, ofs, 2'b00};
    endfunction

    initial begin
        fill_straight();
        // table walk: branch at address 0, slot word at address 4
        for (int v = 0; v < 8; v++) begin
            logic [5:0]  op;
            logic [15:0] ofs;
            logic        dm, tk;
            logic [31:0] exp_pc;
            op  = VECS[v][55:50];
            ofs = VECS[v][49:34];
            dm  = VECS[v][1];
            tk  = VECS[v][0];
            fill_straight();
            mem[0] = {op, 5'd3, 5'd0, ofs};
            rs_value   = VECS[v][33:2];
            rs_ready   = 1'b1;
            delay_mode = dm;
            do_reset();
            @(posedge clk); @(negedge clk);
            chk("R1", "rs_idx", {27'b0, rs_idx}, 32'd3);
            chk("R2", "taken in decode", {31'b0, br_taken}, {31'b0, tk});
            chk("R3", "target", br_target, tgt(ofs));
            @(posedge clk); @(negedge clk);
            exp_pc = tk ? tgt(ofs) : 32'd8;
            if (tk && !dm) begin
                chk("R5", "pc after taken", imem_addr, exp_pc);
                chk("R5", "bubble valid", {31'b0, id_valid}, 32'h0);
                chk("R5", "bubble word", id_instr, 32'h0);
            end else if (tk) begin
                chk("R6", "pc after taken", imem_addr, exp_pc);
                chk("R6", "slot valid", {31'b0, id_valid}, 32'h1);
                chk("R6", "slot word", id_instr, mem[1]);
            end else begin
                chk("R4", "pc not taken", imem_addr, exp_pc);
                chk("R4", "fall-through valid", {31'b0, id_valid}, 32'h1);
                chk("R4", "fall-through word", id_instr, mem[1]);
            end
        end

        // R4: straight-line flow, no lost cycle
        fill_straight();
        delay_mode = 1'b0;
        do_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4", "pc after 3 edges", imem_addr, 32'd12);
        chk("R4", "decode word", id_instr, mem[2]);
        chk("R4", "decode pc4", id_pc4, 32'd12);

        // R7: branch waits on a late operand, then resolves
        fill_straight();
        mem[0] = {6'h04, 5'd7, 5'd0, 16'd5};
        rs_value = '0;
        rs_ready = 1'b0;
        do_reset();
        @(posedge clk); @(negedge clk);
        chk("R7", "hold flag", {31'b0, id_hold}, 32'h1);
        chk("R7", "no redirect while held", {31'b0, br_taken}, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R7", "pc held", imem_addr, 32'd4);
        chk("R7", "word held", id_instr, mem[0]);
        chk("R7", "valid held", {31'b0, id_valid}, 32'h1);
        rs_ready = 1'b1;
        #1;
        chk("R7", "taken once ready", {31'b0, br_taken}, 32'h1);
        @(posedge clk); @(negedge clk);
        chk("R5", "pc after release", imem_addr, 32'd24);
        chk("R5", "bubble after release", {31'b0, id_valid}, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule